// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a synchronous up-counter, four bits wide by default, whose state bits all sit on one clock. On each rising edge it does one of four things: it returns to zero, it takes a parallel word, it steps up by one, or it keeps its value. A zero on the active-low clear pin beats everything else. A zero on the active-low load pin comes next. Counting happens only when both count-enable pins are high. Nothing acts between edges.

A terminal-carry output goes high while the count holds its largest value and the second enable, `ent`, is high. The output is combinational from the state and from `ent`. To build a wider counter, wire the carry of a lower stage to the `ent` of the next stage, and give every stage the same clock, clear, load and `enp`. A higher stage then advances exactly when every stage below it wraps. Two stages chained this way form a 256-state counter.

The block has no stream interface. Every pin is a plain level control or a plain state output, so back-pressure does not apply.

Top module: `sync_cascade_counter`

## Requirements
- R1: When `clear_n` is 0 at a rising edge, `count` becomes 0 after that edge. This holds whatever `load_n`, `din`, `enp` and `ent` are.
- R2: When `clear_n` is 1 and `load_n` is 0 at a rising edge, `count` becomes `din` after that edge. This holds whatever `enp` and `ent` are.
- R3: When `clear_n`, `load_n`, `enp` and `ent` are all 1 at a rising edge, `count` rises by one modulo 2^WIDTH. With WIDTH=4 the value 15 goes to 0.
- R4: When `clear_n` and `load_n` are 1 and `enp` or `ent` is 0 at a rising edge, `count` keeps its value.
- R5: `carry_out` is 1 exactly when `count` is all ones and `ent` is 1. It follows a change of `ent` within the same cycle, with no clock edge needed.
- R6: `count` changes only at a rising clock edge. A change of `din` or of the control pins between edges leaves `count` unchanged until the next edge.
- R7: Two stages chained with the lower `carry_out` driving the upper `ent`, sharing clock, clear, load and `enp`, step through all 256 values in order and wrap from 255 to 0. The upper stage holds the high four bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock; all state changes on its rising edge |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| din | input | WIDTH | Value taken by a load |
| enp | input | 1 | Count enable that does not gate the carry |
| ent | input | 1 | Count enable that also gates the carry |
| count | output | WIDTH | Current counter state |
| carry_out | output | 1 | Terminal carry: all-ones state while `ent` is high |

## Verification
Two instances are chained into an eight-bit counter. A behavioural model of the 256-state value is compared against them after every edge. A long free run crosses every low-nibble wrap and the full 255-to-0 wrap, which separates correct carry chaining from an upper stage that advances early or never. Loads near the wrap points, with the enables held low, show that load beats counting, and a clear asserted together with a load shows that clear beats load. `ent` is toggled while the count sits at all ones and `enp` is dropped on its own, which tells the combinational carry gating apart from the hold behaviour. Inputs are also changed in the middle of a cycle to confirm that nothing moves between edges.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/ctr_mode_sel.sv
module ctr_mode_sel
  import ctr_pkg::*;
(
  input  logic    clear_n,
  input  logic    load_n,
  input  logic    enp,
  input  logic    ent,
  output ctr_op_e op
);
  // Priority: clear, then load, then count, else hold.
  always_comb begin
    if (!clear_n)        op = OP_CLEAR;
    else if (!load_n)    op = OP_LOAD;
    else if (enp && ent) op = OP_COUNT;
    else                 op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_next_state.sv
module ctr_next_state
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  // ones_below[i] is set when every bit under position i is one.
  logic [WIDTH:0]   ones_below;
  logic [WIDTH-1:0] stepped;

  assign ones_below[0] = 1'b1;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      assign ones_below[gi+1] = ones_below[gi] & cur[gi];
      // Toggle-style increment: a bit flips when all lower bits are one.
      assign stepped[gi]      = cur[gi] ^ ones_below[gi];
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = stepped;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/ctr_carry_gen.sv
module ctr_carry_gen #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             ent,
  output logic             carry
);
  localparam logic [WIDTH-1:0] TERMINAL = {WIDTH{1'b1}};
  assign carry = ent && (cur == TERMINAL);
endmodule

// File: rtl/sync_cascade_counter.sv
module sync_cascade_counter
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             enp,
  input  logic             ent,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  ctr_op_e          op;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  ctr_mode_sel u_mode (
    .clear_n (clear_n),
    .load_n  (load_n),
    .enp     (enp),
    .ent     (ent),
    .op      (op)
  );

  ctr_next_state #(.WIDTH(WIDTH)) u_next (
    .op  (op),
    .cur (state_q),
    .din (din),
    .nxt (state_d)
  );

  ctr_carry_gen #(.WIDTH(WIDTH)) u_carry (
    .cur   (state_q),
    .ent   (ent),
    .carry (carry_out)
  );

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end

  assign count = state_q;
endmodule

// File: rtl/ctr_checker.sv
module ctr_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clear_n,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic             enp,
  input logic             ent,
  input logic [WIDTH-1:0] count,
  input logic             carry_out
);
  // The state is only defined once a clear has been taken.
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (!clear_n) armed <= 1'b1;
  end

  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!armed)
    !clear_n |=> count == '0);

  a_r2_load_takes_data: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && !load_n) |=> count == $past(din));

  a_r3_count_step: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && load_n && enp && ent) |=> count == WIDTH'($past(count) + 1'b1));

  a_r4_hold: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && load_n && !(enp && ent)) |=> $stable(count));

  a_r5_carry_needs_ent: assert property (@(posedge clk) disable iff (!armed)
    carry_out |-> (ent && (&count)));

  a_r5_carry_when_full: assert property (@(posedge clk) disable iff (!armed)
    (ent && (&count)) |-> carry_out);
endmodule

bind sync_cascade_counter ctr_checker #(.WIDTH(WIDTH)) u_ctr_checker (
  .clk       (clk),
  .clear_n   (clear_n),
  .load_n    (load_n),
  .din       (din),
  .enp       (enp),
  .ent       (ent),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/test_sync_cascade_counter.sv
`timescale 1ns/100ps
module test_sync_cascade_counter;
  logic       clk = 1'b0;
  logic       clear_n = 1'b1, load_n = 1'b1, enp = 1'b0, ent = 1'b0;
  logic [7:0] din = 8'h00;
  logic [3:0] cnt_lo, cnt_hi;
  logic       cy_lo, cy_hi;

  int n_cmp = 0, n_bad = 0;
  int m_lo = 0, m_hi = 0;   // reference model, nibbles of the 8-bit value
  bit known = 0;

  always #2.5 clk = ~clk;

  sync_cascade_counter #(.WIDTH(4)) i_sync_cascade_counter (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .din(din[3:0]),
    .enp(enp), .ent(ent), .count(cnt_lo), .carry_out(cy_lo));

  sync_cascade_counter #(.WIDTH(4)) i_sync_cascade_counter_upper (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .din(din[7:4]),
    .enp(enp), .ent(cy_lo), .count(cnt_hi), .carry_out(cy_hi));

  task automatic chk(input int got, input int exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Compares the outputs against the model; called between edges.
  task automatic compare_all(input string tag);
    bit mc_lo = ent && (m_lo == 15);
    bit mc_hi = mc_lo && (m_hi == 15);
    chk(cnt_lo, m_lo, {tag, " lo"});
    chk(cnt_hi, m_hi, {tag, " hi R7"});
    chk(cy_lo, mc_lo, "R5 carry lo");
    chk(cy_hi, mc_hi, "R5/R7 carry hi");
  endtask

  // One clock: apply inputs after a falling edge, check, take the edge, update model.
  task automatic step(input bit c, input bit l, input logic [7:0] d,
                      input bit p, input bit t, input string tag);
    int o_lo, o_hi;
    bit c_lo;
    @(negedge clk);
    clear_n = c; load_n = l; din = d; enp = p; ent = t;
    #0.5;
    if (known) compare_all("R6 mid-cycle");
    o_lo = m_lo; o_hi = m_hi; c_lo = t && (o_lo == 15);
    if (!c) begin m_lo = 0; m_hi = 0; known = 1; end
    else if (!l) begin m_lo = d[3:0]; m_hi = d[7:4]; end
    else begin
      if (p && t)    m_lo = (o_lo + 1) % 16;
      if (p && c_lo) m_hi = (o_hi + 1) % 16;
    end
    @(posedge clk);
    #1;
    if (known) compare_all(tag);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: clear with load and enables active still gives zero
    step(0, 0, 8'hA5, 1, 1, "R1 reset clear");
    chk({cnt_hi, cnt_lo}, 0, "R1 reset state");
    // R3/R7: full run across every wrap including 255 -> 0
    for (int i = 0; i < 260; i++) step(1, 1, 8'h3C, 1, 1, "R3 count");
    // R4: enp low holds; ent low holds
    for (int i = 0; i < 3; i++) step(1, 1, 8'h00, 0, 1, "R4 hold enp");
    for (int i = 0; i < 3; i++) step(1, 1, 8'h00, 1, 0, "R4 hold ent");
    // R2: load with enables off, near a nibble wrap
    step(1, 0, 8'hEE, 0, 0, "R2 load");
    for (int i = 0; i < 4; i++) step(1, 1, 8'h00, 1, 1, "R3 past nibble wrap");
    // R5: sit at all ones and toggle ent with enp low
    step(1, 0, 8'hFF, 1, 1, "R2 load max");
    step(1, 1, 8'h00, 0, 1, "R5 ent high");
    step(1, 1, 8'h00, 0, 0, "R5 ent low");
    step(1, 1, 8'h00, 0, 1, "R5 ent high again");
    step(1, 1, 8'h00, 1, 1, "R3 full wrap");
    // R1 over load: clear and load together
    step(1, 0, 8'h77, 1, 1, "R2 load mid");
    step(0, 0, 8'h99, 1, 1, "R1 clear beats load");
    // R6: data changes mid-cycle with load inactive
    for (int i = 0; i < 20; i++) step(1, 1, 8'(i * 37), 1, 1, "R6 data churn");
    step(1, 0, 8'h0F, 1, 0, "R2 load ignores enables");
    step(1, 1, 8'h00, 1, 1, "R7 lower carry steps upper");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule